// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block owns the receive side of a descriptor ring kept in system memory. Each ring entry is two 32-bit words. The first word holds a buffer address, a wrap marker and an ownership marker. The second word receives the status of the frame. When the receiver reports that a frame has begun, the manager reads the current entry and checks who owns it. If hardware may use the buffer, the manager presents the buffer address to the data mover until the frame ends. On a clean end it returns the entry to software and moves to the next entry. On an error end it keeps the entry and reuses the buffer.

If software still holds the entry, the frame is dropped. A sticky status bit is raised and counted, and the same entry is polled again when the next frame starts. The entry address is formed by ORing a ring counter, scaled to eight bytes per entry, into a base pointer set by software. The counter returns to zero after an entry carrying the wrap marker is used. It also returns to zero after a parameterised maximum number of entries.

Top module: `rxq_ring_mgr`

## Requirements
- R1: After reset the control, status, base pointer and drop count all read zero, `irq` is low, `buf_valid` is low and `mem_req` is low.
- R2: While control bit 0 (receive enable, register offset 0) is clear, `frm_start` causes no memory access.
- R3: With receive enable set, `frm_start` makes the block read word 0 of the current entry at address base OR (index × 8).
- R4: If the fetched word 0 has bit 0 clear, `buf_valid` is high and `buf_addr` equals word 0 with bits [1:0] zeroed until the frame ends. A good end (`frm_good`) writes word 0 back with bit 0 set and bit 1 kept, then writes word 1 at the entry address + 4 as {`frm_match`[3:0] in bits [31:28], zeros, `frm_len` in bits [10:0]}. Bit 31 is the all-ones broadcast flag.
- R5: An error end (`frm_bad`) writes nothing, and the next frame uses the same entry.
- R6: After a good frame the index advances by one. If the used entry had word 0 bit 1 (wrap) set, the index returns to zero instead.
- R7: After the entry at index MAX_ENTRIES-1 is used, the index returns to zero even when that entry's wrap bit is clear.
- R8: If the fetched word 0 has bit 0 set, status bit 0 (register offset 2) is set. Nothing is written, and the next frame start re-reads the same entry.
- R9: Each dropped frame increments the drop count (register offset 3), which saturates at 2^DROP_W-1. A read returns the current value and clears the count.
- R10: Reading offset 1 returns base OR (index × 8). Writing offset 1 loads the base and sets the index to zero.
- R11: Status bit 1 is set when a frame is stored. Writing 1 to a status bit clears it. `irq` is high while (status bit 0 AND control bit 1) OR (status bit 1 AND control bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears drop count at offset 3) |
| reg_addr | input | 2 | Register offset: 0 control, 1 base/current pointer, 2 status, 3 drop count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| frm_start | input | 1 | Pulse: a frame has begun |
| frm_good | input | 1 | Pulse: frame ended without error |
| frm_bad | input | 1 | Pulse: frame ended in error |
| frm_len | input | LEN_W | Frame length, valid with the end pulse |
| frm_match | input | MATCH_W | Address recognition flags, MSB = broadcast |
| buf_addr | output | 32 | Buffer address for the data mover |
| buf_valid | output | 1 | Buffer is granted for the current frame |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with MAX_ENTRIES = 4, so the ring index takes only two bits. An eight-frame sequence therefore runs through the forced wrap at the last entry and back around. The explicit wrap marker is tested on entry 1, and that short ring makes it easy to see. DROP_W stays at 8, and a few hundred dropped frames drive the counter into saturation.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_RECV,
        ST_WB_ADDR,
        ST_WB_STAT
    } rxq_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_QPTR = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_DROP = 2'd3;

    localparam int CTRL_EN      = 0;
    localparam int CTRL_IE_BUSY = 1;
    localparam int CTRL_IE_DONE = 2;
    localparam int CTRL_W       = 3;

    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_W    = 2;

    localparam int W0_OWN  = 0;
    localparam int W0_WRAP = 1;
endpackage

// File: rtl/rxq_ring_index.sv
module rxq_ring_index #(
    parameter int MAX_ENTRIES = 1024,
    parameter int IDX_W       = $clog2(MAX_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic             wrap_hint,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(MAX_ENTRIES - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clear) begin
            idx_d = '0;
        end else if (advance) begin
            if (wrap_hint || idx_q == LAST) begin
                idx_d = '0;
            end else begin
                idx_d = idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx = idx_q;
endmodule

// File: rtl/rxq_csr.sv
module rxq_csr
    import rxq_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [WORD_W-1:0] desc_addr,
    input  logic              set_busy,
    input  logic              set_done,
    input  logic              drop_inc,
    output logic              rx_en,
    output logic [WORD_W-1:0] base,
    output logic              ring_clear,
    output logic              irq,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [WORD_W-1:0] base;
        logic [STAT_W-1:0] stat;
        logic [DROP_W-1:0] drops;
    } csr_t;

    csr_t r_d, r_q;
    logic [DROP_W-1:0] drop_base;
    logic              rd_clear;

    always_comb begin
        r_d      = r_q;
        rd_clear = reg_rd && (reg_addr == REG_DROP);
        if (reg_wr && reg_addr == REG_CTRL) begin
            r_d.ctrl = reg_wdata[CTRL_W-1:0];
        end
        if (reg_wr && reg_addr == REG_QPTR) begin
            r_d.base = reg_wdata;
        end
        if (reg_wr && reg_addr == REG_STAT) begin
            r_d.stat = r_q.stat & ~reg_wdata[STAT_W-1:0];
        end
        if (set_busy) begin
            r_d.stat[STAT_BUSY] = 1'b1;
        end
        if (set_done) begin
            r_d.stat[STAT_DONE] = 1'b1;
        end
        drop_base = rd_clear ? '0 : r_q.drops;
        if (drop_inc && drop_base != DROP_MAX) begin
            r_d.drops = drop_base + 1'b1;
        end else begin
            r_d.drops = drop_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_CTRL: reg_rdata = WORD_W'(r_q.ctrl);
            REG_QPTR: reg_rdata = desc_addr;
            REG_STAT: reg_rdata = WORD_W'(r_q.stat);
            default:  reg_rdata = WORD_W'(r_q.drops);
        endcase
    end

    assign rx_en      = r_q.ctrl[CTRL_EN];
    assign base       = r_q.base;
    assign ring_clear = reg_wr && (reg_addr == REG_QPTR);
    assign drop_cnt   = r_q.drops;
    assign irq        = (r_q.stat[STAT_BUSY] && r_q.ctrl[CTRL_IE_BUSY]) ||
                        (r_q.stat[STAT_DONE] && r_q.ctrl[CTRL_IE_DONE]);
endmodule

// File: rtl/rxq_desc_fsm.sv
module rxq_desc_fsm
    import rxq_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int MATCH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               frm_start,
    input  logic               frm_good,
    input  logic               frm_bad,
    input  logic [LEN_W-1:0]   frm_len,
    input  logic [MATCH_W-1:0] frm_match,
    input  logic [WORD_W-1:0]  desc_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WORD_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic [WORD_W-1:0]  buf_addr,
    output logic               buf_valid,
    output logic               set_busy,
    output logic               set_done,
    output logic               drop_inc,
    output logic               advance,
    output logic               wrap_hint
);
    localparam logic [WORD_W-1:0] STAT_OFS = WORD_W'(4);

    typedef struct packed {
        rxq_state_e         state;
        logic [WORD_W-1:0]  word0;
        logic               end_seen;
        logic               end_ok;
        logic [LEN_W-1:0]   len;
        logic [MATCH_W-1:0] match;
    } fsm_t;

    fsm_t s_d, s_q;
    logic end_now;

    always_comb begin
        s_d       = s_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        buf_valid = 1'b0;
        set_busy  = 1'b0;
        set_done  = 1'b0;
        drop_inc  = 1'b0;
        advance   = 1'b0;
        wrap_hint = 1'b0;
        end_now   = frm_good || frm_bad;

        if (s_q.state != ST_IDLE && end_now && !s_q.end_seen) begin
            s_d.end_seen = 1'b1;
            s_d.end_ok   = frm_good;
            s_d.len      = frm_len;
            s_d.match    = frm_match;
        end

        case (s_q.state)
            ST_IDLE: begin
                s_d.end_seen = 1'b0;
                if (frm_start && rx_en) begin
                    s_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req   = 1'b1;
                s_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if (mem_rdata[W0_OWN]) begin
                    set_busy  = 1'b1;
                    drop_inc  = 1'b1;
                    s_d.state = ST_IDLE;
                end else begin
                    s_d.word0 = mem_rdata;
                    s_d.state = ST_RECV;
                end
            end
            ST_RECV: begin
                buf_valid = 1'b1;
                if (s_q.end_seen) begin
                    s_d.state = s_q.end_ok ? ST_WB_ADDR : ST_IDLE;
                end
            end
            ST_WB_ADDR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = s_q.word0;
                mem_wdata[W0_OWN] = 1'b1;
                s_d.state = ST_WB_STAT;
            end
            ST_WB_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr | STAT_OFS;
                mem_wdata[LEN_W-1:0]          = s_q.len;
                mem_wdata[WORD_W-1 -: MATCH_W] = s_q.match;
                set_done  = 1'b1;
                advance   = 1'b1;
                wrap_hint = s_q.word0[W0_WRAP];
                s_d.state = ST_IDLE;
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign buf_addr = {s_q.word0[WORD_W-1:2], 2'b00};
endmodule

// File: rtl/rxq_ring_mgr.sv
module rxq_ring_mgr
    import rxq_pkg::*;
#(
    parameter int MAX_ENTRIES = 1024,
    parameter int LEN_W       = 11,
    parameter int MATCH_W     = 4,
    parameter int DROP_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    input  logic               frm_start,
    input  logic               frm_good,
    input  logic               frm_bad,
    input  logic [LEN_W-1:0]   frm_len,
    input  logic [MATCH_W-1:0] frm_match,
    output logic [31:0]        buf_addr,
    output logic               buf_valid,
    output logic               irq
);
    localparam int IDX_W = $clog2(MAX_ENTRIES);

    logic              rx_en;
    logic [31:0]       base;
    logic              ring_clear;
    logic [IDX_W-1:0]  ring_idx;
    logic [DROP_W-1:0] drop_cnt;
    logic [31:0]       desc_addr;
    logic              set_busy, set_done, drop_inc, advance, wrap_hint;

    assign desc_addr = base | 32'({ring_idx, 3'b000});

    rxq_csr #(.DROP_W(DROP_W)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .desc_addr  (desc_addr),
        .set_busy   (set_busy),
        .set_done   (set_done),
        .drop_inc   (drop_inc),
        .rx_en      (rx_en),
        .base       (base),
        .ring_clear (ring_clear),
        .irq        (irq),
        .drop_cnt   (drop_cnt)
    );

    rxq_ring_index #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ring_clear),
        .advance   (advance),
        .wrap_hint (wrap_hint),
        .idx       (ring_idx)
    );

    rxq_desc_fsm #(.LEN_W(LEN_W), .MATCH_W(MATCH_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .frm_start (frm_start),
        .frm_good  (frm_good),
        .frm_bad   (frm_bad),
        .frm_len   (frm_len),
        .frm_match (frm_match),
        .desc_addr (desc_addr),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .buf_addr  (buf_addr),
        .buf_valid (buf_valid),
        .set_busy  (set_busy),
        .set_done  (set_done),
        .drop_inc  (drop_inc),
        .advance   (advance),
        .wrap_hint (wrap_hint)
    );
endmodule

// File: rtl/rxq_ring_mgr_chk.sv
module rxq_ring_mgr_chk #(
    parameter int IDX_W  = 10,
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [31:0]       mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              rx_en,
    input logic [IDX_W-1:0]  ring_idx,
    input logic [DROP_W-1:0] drop_cnt,
    input logic              drop_inc
);
    localparam logic [IDX_W-1:0]  IDX_ONE  = IDX_W'(1);
    localparam logic [DROP_W-1:0] DROP_ONE = DROP_W'(1);

    // R4: a write only happens as part of an access
    p_we_in_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R4: word 0 is only ever written back with the ownership bit set
    p_word0_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_addr[2]) |-> mem_wdata[0]);

    // R2: a descriptor read follows a cycle with receive enabled
    p_fetch_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> $past(rx_en));

    // R6: the ring index only steps by one or returns to zero
    p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_idx != $past(ring_idx)) |->
        (ring_idx == '0 || ring_idx == $past(ring_idx) + IDX_ONE));

    // R9: the drop count only steps by one or is cleared
    p_drop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |->
        (drop_cnt == $past(drop_cnt) + DROP_ONE || drop_cnt <= DROP_ONE));

    // R8: a dropped frame causes no write in the next cycle
    p_drop_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(drop_inc) |-> !mem_we);
endmodule

bind rxq_ring_mgr rxq_ring_mgr_chk #(.IDX_W(IDX_W), .DROP_W(DROP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rx_en     (rx_en),
    .ring_idx  (ring_idx),
    .drop_cnt  (drop_cnt),
    .drop_inc  (drop_inc)
);

// File: tb/rxq_ring_mgr_bench.sv
`timescale 1ns/1ps
module rxq_ring_mgr_bench;
    localparam int ENTRIES = 4;
    localparam int LEN_W   = 11;
    localparam int MATCH_W = 4;
    localparam logic [31:0] BASE = 32'h40;
    localparam int NVEC = 8;
    // vector: {bad, len[10:0], match[3:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0, 11'd64,   4'b1000},
        {1'b0, 11'd1518, 4'b0001},
        {1'b1, 11'd100,  4'b0000},
        {1'b0, 11'd200,  4'b0010},
        {1'b0, 11'd2047, 4'b1100},
        {1'b0, 11'd77,   4'b0100},
        {1'b1, 11'd33,   4'b1000},
        {1'b0, 11'd1,    4'b1001}
    };

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic frm_start = 0, frm_good = 0, frm_bad = 0;
    logic [LEN_W-1:0] frm_len = 0;
    logic [MATCH_W-1:0] frm_match = 0;
    logic [31:0] buf_addr;
    logic buf_valid, irq;

    logic [31:0] mem [64];
    logic [31:0] rd_q;
    int wr_count = 0, rd_count = 0;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[7:2]] <= mem_wdata;
                wr_count <= wr_count + 1;
            end else begin
                rd_q <= mem[mem_addr[7:2]];
                rd_count <= rd_count + 1;
            end
        end
    end
    assign mem_rdata = rd_q;

    rxq_ring_mgr #(.MAX_ENTRIES(ENTRIES), .LEN_W(LEN_W), .MATCH_W(MATCH_W), .DROP_W(8)) u_rxq_ring_mgr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .frm_start(frm_start), .frm_good(frm_good), .frm_bad(frm_bad), .frm_len(frm_len),
        .frm_match(frm_match), .buf_addr(buf_addr), .buf_valid(buf_valid), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic start_frame();
        @(negedge clk);
        frm_start = 1;
        @(negedge clk);
        frm_start = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic end_frame(input logic bad, input logic [LEN_W-1:0] len, input logic [MATCH_W-1:0] m);
        @(negedge clk);
        frm_good = !bad; frm_bad = bad; frm_len = len; frm_match = m;
        @(negedge clk);
        frm_good = 0; frm_bad = 0;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [31:0] buf_of(input int k);
        return 32'h1000 * (k + 1);
    endfunction

    function automatic int w0(input int k);
        return 16 + 2 * k;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int idx_m, wc0, rc0;
        for (int i = 0; i < 64; i++) mem[i] = 0;
        rd_q = 0;
        repeat (3) @(negedge clk);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 mem_req", {31'd0, mem_req}, 0);
        rst_n = 1;
        rd_reg(2'd0, v); check("R1 ctrl", v, 0);
        rd_reg(2'd1, v); check("R1 qptr", v, 0);
        rd_reg(2'd2, v); check("R1 stat", v, 0);
        rd_reg(2'd3, v); check("R1 drops", v, 0);
        check("R1 buf_valid", {31'd0, buf_valid}, 0);

        // R2: disabled receiver ignores frame starts
        wr_reg(2'd1, BASE);
        rc0 = rd_count;
        start_frame();
        end_frame(0, 11'd10, 4'd0);
        check("R2 no fetch while disabled", rd_count, rc0);

        wr_reg(2'd0, 32'h1);
        for (int k = 0; k < ENTRIES; k++) mem[w0(k)] = buf_of(k);
        rd_reg(2'd1, v); check("R10 qptr after write", v, BASE);

        // vector walk over ring of ENTRIES without wrap bits (R3 R4 R5 R7)
        idx_m = 0;
        for (int n = 0; n < NVEC; n++) begin
            logic bad;
            logic [LEN_W-1:0] len;
            logic [MATCH_W-1:0] m;
            {bad, len, m} = VEC[n];
            mem[w0(idx_m)] = buf_of(idx_m);
            mem[w0(idx_m) + 1] = 0;
            wc0 = wr_count;
            start_frame();
            check("R3 R4 buffer granted", {31'd0, buf_valid}, 1);
            check("R3 R4 buffer address", buf_addr, buf_of(idx_m));
            end_frame(bad, len, m);
            if (!bad) begin
                check("R4 word0 writeback", mem[w0(idx_m)], buf_of(idx_m) | 32'h1);
                check("R4 word1 status", mem[w0(idx_m) + 1], {m, 17'd0, len});
                idx_m = (idx_m == ENTRIES - 1) ? 0 : idx_m + 1;
            end else begin
                check("R5 no write on error", wr_count, wc0);
            end
            rd_reg(2'd1, v);
            check("R6 R7 ring index", v, BASE | 32'(idx_m * 8));
        end

        // R6: explicit wrap bit on entry 1
        wr_reg(2'd1, BASE);
        mem[w0(0)] = buf_of(0);
        mem[w0(1)] = buf_of(1) | 32'h2;
        start_frame(); end_frame(0, 11'd5, 4'd0);
        start_frame(); end_frame(0, 11'd6, 4'd0);
        check("R6 wrap bit kept", mem[w0(1)], buf_of(1) | 32'h3);
        rd_reg(2'd1, v); check("R6 wrap to start", v, BASE);

        // R11: done status and irq, then W1C
        wr_reg(2'd0, 32'h5);
        rd_reg(2'd2, v); check("R11 done status", v & 32'h2, 32'h2);
        check("R11 irq on done", {31'd0, irq}, 1);
        wr_reg(2'd2, 32'h3);
        rd_reg(2'd2, v); check("R11 w1c", v, 0);
        check("R11 irq low", {31'd0, irq}, 0);

        // R8: busy descriptor is dropped and re-polled
        wr_reg(2'd0, 32'h3);
        mem[w0(0)] = buf_of(0) | 32'h1;
        mem[w0(0) + 1] = 32'hDEAD;
        rd_reg(2'd3, v);
        wc0 = wr_count;
        start_frame();
        check("R8 no grant", {31'd0, buf_valid}, 0);
        end_frame(0, 11'd9, 4'd0);
        check("R8 no write", wr_count, wc0);
        check("R8 status word untouched", mem[w0(0) + 1], 32'hDEAD);
        rd_reg(2'd2, v); check("R8 busy status", v, 32'h1);
        check("R8 irq", {31'd0, irq}, 1);
        rd_reg(2'd1, v); check("R8 index held", v, BASE);
        rd_reg(2'd3, v); check("R9 one drop", v, 1);
        rd_reg(2'd3, v); check("R9 cleared on read", v, 0);
        mem[w0(0)] = buf_of(0);
        rc0 = rd_count;
        start_frame();
        check("R8 re-read same entry", buf_addr, buf_of(0));
        end_frame(0, 11'd12, 4'd0);
        check("R8 stored after release", mem[w0(0)], buf_of(0) | 32'h1);

        // R9: saturation
        mem[w0(1)] = buf_of(1) | 32'h1;
        for (int n = 0; n < 260; n++) begin
            @(negedge clk); frm_start = 1;
            @(negedge clk); frm_start = 0;
            repeat (3) @(negedge clk);
        end
        rd_reg(2'd3, v); check("R9 saturates", v, 255);
        rd_reg(2'd3, v); check("R9 clear after saturation", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule